// File: doc/BRIEF.md
# USB Device Bus Presence Controller

This block turns three software controls into the signals that decide whether a USB device is visible on the bus. The controls are a soft-disconnect request, a remote-wakeup request and a global NAK request for non-periodic IN endpoints. A soft disconnect drives the transceiver operating mode into its non-driving setting, so the host sees the device leave. Clearing the request lets the device reappear, and the host then enumerates it again. The IN handshake select for each endpoint is worked out combinationally. It comes from the transmit-FIFO data flags, and the global NAK request overrides it on every endpoint marked non-periodic.

Two microsecond timers watch how software uses the controls. The first measures each soft disconnect against the shortest time the host needs to notice it. That time depends on the bus speed and the device state sampled when the disconnect began, plus a jitter margin. When the time has passed, a status flag rises. The second timer bounds remote-wakeup signaling to a window of 1 ms to 15 ms. It stops resume signaling at the upper bound and raises an error flag if the request ends too early or runs too long. All pins are plain level controls and status. The block has no streaming data path, so it has no valid/ready handshake.

Top module: `usbdev_presence_ctrl`

## Requirements
- R1: While `i_soft_disc` is 1, `o_opmode` is 2'b01 in the same cycle.
- R2: While `i_soft_disc` is 0, `o_opmode` is 2'b00. The device stays disconnected until `i_soft_disc` is cleared.
- R3: While `i_gnp_nak` is 1, every endpoint whose bit is set in `NP_EP_MASK` has `o_in_nak` bit = 1, meaning NAK. The default mask is 4'b0111, so endpoint 3 is periodic.
- R4: With `i_gnp_nak` at 0, or on a periodic endpoint, `o_in_nak[e]` is the inverse of `i_fifo_avail[e]`: NAK when the FIFO is empty, data otherwise.
- R5: `o_disc_seen` rises once the soft disconnect has lasted L ticks, where L is a base limit plus `i_margin_us`. The encodings are: speed 00 = high, 01 = full, 10 = low; state 00 = active, 01 = idle, 10 = suspended. The half-microsecond term is rounded up. High-speed bases are 1003 (suspended), 3003 (idle) and 125 (active). Full- and low-speed bases are 1003 (suspended) and 3 (idle or active). With a tick on every cycle, `o_disc_seen` is 0 after L posedges counted from the first edge that sees `i_soft_disc` high, and 1 after L+1.
- R6: Speed, state and margin are sampled at the rising edge of the soft disconnect, and later changes do not alter L. A tick in that first cycle is not counted. `o_disc_seen` is 0 whenever `i_soft_disc` is 0.
- R7: The rising edge of `i_rwake_req` is accepted when `i_soft_disc` is 0. After that edge, `o_resume_en` is 1 while the state is suspended (2'b10). If the state was suspended at acceptance, `o_susp_exit` is a single-cycle pulse.
- R8: If an accepted request falls after fewer than 1000 counted ticks, `o_wake_early_err` is set. A fall at exactly 1000 ticks sets nothing.
- R9: When an accepted request reaches 15000 counted ticks, `o_resume_en` drops and `o_wake_overrun_err` is set at the same edge. A later fall raises no early error.
- R10: A wakeup rising edge seen while `i_soft_disc` is 1 is ignored: no resume, no pulse, and the error flags are unchanged. `o_resume_en` is also 0 whenever the state is not suspended.
- R11: Both error flags are sticky until the next accepted wakeup request.
- R12: After reset, `o_opmode` is 00, `o_in_nak` follows the FIFO flags, and `o_resume_en`, `o_susp_exit`, `o_disc_seen` and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_soft_disc | input | 1 | Soft-disconnect request |
| i_rwake_req | input | 1 | Remote-wakeup request |
| i_gnp_nak | input | 1 | Global non-periodic IN NAK request |
| i_speed | input | 2 | Bus speed: 00 high, 01 full, 10 low |
| i_dev_state | input | 2 | Device state: 00 active, 01 idle, 10 suspended |
| i_fifo_avail | input | NUM_EP | Per-endpoint transmit FIFO holds data |
| i_tick | input | 1 | One-cycle microsecond tick |
| i_margin_us | input | 8 | Jitter margin added to the disconnect limit |
| o_opmode | output | 2 | Transceiver operating mode |
| o_in_nak | output | NUM_EP | Per-endpoint IN handshake: 1 NAK, 0 data |
| o_resume_en | output | 1 | Drive resume signaling toward the host |
| o_susp_exit | output | 1 | One-cycle suspend-exit pulse |
| o_disc_seen | output | 1 | Disconnect has lasted long enough for the host to see it |
| o_wake_early_err | output | 1 | Wakeup request cleared before 1 ms |
| o_wake_overrun_err | output | 1 | Wakeup request still set at 15 ms |

## Verification
The assertions assume that `i_dev_state` never takes the reserved value 2'b11. They also assume that `i_tick` is a clean single-cycle strobe, so the counters advance by at most one per clock. The bench drives speed and state only from the defined encodings. It changes every input half a cycle away from the sampling edge. It holds the tick high through the timing checks, so the expected edge counts stay exact. Random vectors are used only for the combinational handshake and opmode paths.

// File: rtl/usbdev_presence_pkg.sv
package usbdev_presence_pkg;
  typedef enum logic [1:0] {SPD_HIGH = 2'b00, SPD_FULL = 2'b01, SPD_LOW = 2'b10} speed_e;
  typedef enum logic [1:0] {ST_ACTIVE = 2'b00, ST_IDLE = 2'b01, ST_SUSP = 2'b10} devst_e;
  localparam logic [1:0] OPM_NORMAL = 2'b00;
  localparam logic [1:0] OPM_NODRIVE = 2'b01;
endpackage

// File: rtl/usbdev_disc_timer.sv
module usbdev_disc_timer
  import usbdev_presence_pkg::*;
#(
  parameter int MIN_HS_SUSP = 1003,
  parameter int MIN_HS_IDLE = 3003,
  parameter int MIN_HS_ACT  = 125,
  parameter int MIN_FS_SUSP = 1003,
  parameter int MIN_FS_IDLE = 3,
  parameter int MIN_FS_ACT  = 3,
  parameter int MARGIN_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                i_soft_disc,
  input  logic                i_tick,
  input  logic [1:0]          i_speed,
  input  logic [1:0]          i_dev_state,
  input  logic [MARGIN_W-1:0] i_margin_us,
  output logic                o_seen
);
  localparam int BASE_MAX = MIN_HS_IDLE;
  localparam int LIM_MAX  = BASE_MAX + (1 << MARGIN_W) - 1;
  localparam int CW       = $clog2(LIM_MAX + 1);

  logic          sd_q, active_q;
  logic [CW-1:0] cnt_q, lim_q, base;

  // base limit from sampled speed and state; reserved codes fall to the active case
  always_comb begin
    if (i_speed == SPD_HIGH) begin
      case (i_dev_state)
        ST_SUSP: base = CW'(MIN_HS_SUSP);
        ST_IDLE: base = CW'(MIN_HS_IDLE);
        default: base = CW'(MIN_HS_ACT);
      endcase
    end else begin
      case (i_dev_state)
        ST_SUSP: base = CW'(MIN_FS_SUSP);
        ST_IDLE: base = CW'(MIN_FS_IDLE);
        default: base = CW'(MIN_FS_ACT);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sd_q     <= 1'b0;
      active_q <= 1'b0;
      cnt_q    <= '0;
      lim_q    <= '0;
    end else begin
      sd_q <= i_soft_disc;
      if (!i_soft_disc) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else if (!sd_q) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        lim_q    <= base + CW'(i_margin_us);
      end else if (i_tick && cnt_q < lim_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign o_seen = i_soft_disc && active_q && (cnt_q >= lim_q);
endmodule

// File: rtl/usbdev_wake_window.sv
module usbdev_wake_window
  import usbdev_presence_pkg::*;
#(
  parameter int WAKE_MIN = 1000,
  parameter int WAKE_MAX = 15000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       i_req,
  input  logic       i_soft_disc,
  input  logic       i_tick,
  input  logic [1:0] i_dev_state,
  output logic       o_resume_en,
  output logic       o_susp_exit,
  output logic       o_early_err,
  output logic       o_overrun_err
);
  localparam int CW = $clog2(WAKE_MAX + 1);

  logic          req_q, armed_q, exit_q, early_q, ovr_q;
  logic [CW-1:0] cnt_q;
  logic          rise, fall, susp;

  assign rise = i_req && !req_q;
  assign fall = !i_req && req_q;
  assign susp = (i_dev_state == ST_SUSP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      armed_q <= 1'b0;
      exit_q  <= 1'b0;
      early_q <= 1'b0;
      ovr_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      req_q  <= i_req;
      exit_q <= 1'b0;
      if (rise) begin
        if (!i_soft_disc) begin
          armed_q <= 1'b1;
          cnt_q   <= '0;
          early_q <= 1'b0;
          ovr_q   <= 1'b0;
          exit_q  <= susp;
        end
      end else if (armed_q) begin
        if (fall) begin
          armed_q <= 1'b0;
          early_q <= (cnt_q < CW'(WAKE_MIN));
        end else if (i_tick) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q + 1'b1 >= CW'(WAKE_MAX)) begin
            armed_q <= 1'b0;
            ovr_q   <= 1'b1;
          end
        end
      end
    end
  end

  assign o_resume_en   = armed_q && susp && !i_soft_disc;
  assign o_susp_exit   = exit_q;
  assign o_early_err   = early_q;
  assign o_overrun_err = ovr_q;
endmodule

// File: rtl/usbdev_in_handshake.sv
module usbdev_in_handshake #(
  parameter int                NUM_EP     = 4,
  parameter logic [NUM_EP-1:0] NP_EP_MASK = 4'b0111
) (
  input  logic              i_gnp_nak,
  input  logic [NUM_EP-1:0] i_fifo_avail,
  output logic [NUM_EP-1:0] o_nak
);
  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    if (NP_EP_MASK[e]) begin : g_np
      assign o_nak[e] = i_gnp_nak || !i_fifo_avail[e];
    end else begin : g_per
      assign o_nak[e] = !i_fifo_avail[e];
    end
  end
endmodule

// File: rtl/usbdev_presence_ctrl.sv
module usbdev_presence_ctrl
  import usbdev_presence_pkg::*;
#(
  parameter int                NUM_EP     = 4,
  parameter logic [NUM_EP-1:0] NP_EP_MASK = 4'b0111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_soft_disc,
  input  logic              i_rwake_req,
  input  logic              i_gnp_nak,
  input  logic [1:0]        i_speed,
  input  logic [1:0]        i_dev_state,
  input  logic [NUM_EP-1:0] i_fifo_avail,
  input  logic              i_tick,
  input  logic [7:0]        i_margin_us,
  output logic [1:0]        o_opmode,
  output logic [NUM_EP-1:0] o_in_nak,
  output logic              o_resume_en,
  output logic              o_susp_exit,
  output logic              o_disc_seen,
  output logic              o_wake_early_err,
  output logic              o_wake_overrun_err
);
  assign o_opmode = i_soft_disc ? OPM_NODRIVE : OPM_NORMAL;

  usbdev_in_handshake #(.NUM_EP(NUM_EP), .NP_EP_MASK(NP_EP_MASK)) u_hs (
    .i_gnp_nak   (i_gnp_nak),
    .i_fifo_avail(i_fifo_avail),
    .o_nak       (o_in_nak)
  );

  usbdev_disc_timer #(.MARGIN_W(8)) u_disc (
    .clk        (clk),
    .rst_n      (rst_n),
    .i_soft_disc(i_soft_disc),
    .i_tick     (i_tick),
    .i_speed    (i_speed),
    .i_dev_state(i_dev_state),
    .i_margin_us(i_margin_us),
    .o_seen     (o_disc_seen)
  );

  usbdev_wake_window #(.WAKE_MIN(1000), .WAKE_MAX(15000)) u_wake (
    .clk          (clk),
    .rst_n        (rst_n),
    .i_req        (i_rwake_req),
    .i_soft_disc  (i_soft_disc),
    .i_tick       (i_tick),
    .i_dev_state  (i_dev_state),
    .o_resume_en  (o_resume_en),
    .o_susp_exit  (o_susp_exit),
    .o_early_err  (o_wake_early_err),
    .o_overrun_err(o_wake_overrun_err)
  );
endmodule

// File: rtl/usbdev_presence_chk.sv
module usbdev_presence_chk
  import usbdev_presence_pkg::*;
#(
  parameter int                NUM_EP     = 4,
  parameter logic [NUM_EP-1:0] NP_EP_MASK = 4'b0111
) (
  input logic              clk,
  input logic              rst_n,
  input logic              i_soft_disc,
  input logic              i_rwake_req,
  input logic              i_gnp_nak,
  input logic [1:0]        i_speed,
  input logic [1:0]        i_dev_state,
  input logic [NUM_EP-1:0] i_fifo_avail,
  input logic              i_tick,
  input logic [7:0]        i_margin_us,
  input logic [1:0]        o_opmode,
  input logic [NUM_EP-1:0] o_in_nak,
  input logic              o_resume_en,
  input logic              o_susp_exit,
  input logic              o_disc_seen,
  input logic              o_wake_early_err,
  input logic              o_wake_overrun_err
);
  AST_SEEN_ONLY_DISCONNECTED: assert property (@(posedge clk) disable iff (!rst_n)
    o_disc_seen |-> o_opmode == OPM_NODRIVE); // R6
  AST_SEEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (o_disc_seen && i_soft_disc) |=> (o_disc_seen || !i_soft_disc)); // R5
  AST_RESUME_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    o_resume_en |-> (o_opmode == OPM_NORMAL && i_dev_state == ST_SUSP)); // R10
  AST_EXIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    o_susp_exit |=> !o_susp_exit); // R7
  AST_NP_NAK_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    i_gnp_nak |-> ((o_in_nak & NP_EP_MASK) == NP_EP_MASK)); // R3
  AST_OVERRUN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(o_wake_overrun_err) |-> !o_resume_en); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (o_wake_early_err && !i_rwake_req) |=> o_wake_early_err); // R11
endmodule

bind usbdev_presence_ctrl usbdev_presence_chk #(.NUM_EP(NUM_EP), .NP_EP_MASK(NP_EP_MASK)) u_chk (.*);

// File: tb/usbdev_presence_ctrl_bench.sv
module usbdev_presence_ctrl_bench;
  localparam int NUM_EP = 4;
  localparam logic [NUM_EP-1:0] NPM = 4'b0111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sd = 0, rw = 0, gn = 0, tick = 1;
  logic [1:0] spd = 0, st = 0;
  logic [NUM_EP-1:0] fifo = 4'b1010;
  logic [7:0] margin = 0;
  logic [1:0] opm;
  logic [NUM_EP-1:0] nak;
  logic res_en, sexit, seen, eerr, oerr;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  usbdev_presence_ctrl #(.NUM_EP(NUM_EP), .NP_EP_MASK(NPM)) u_usbdev_presence_ctrl (
    .clk(clk), .rst_n(rst_n), .i_soft_disc(sd), .i_rwake_req(rw), .i_gnp_nak(gn),
    .i_speed(spd), .i_dev_state(st), .i_fifo_avail(fifo), .i_tick(tick),
    .i_margin_us(margin), .o_opmode(opm), .o_in_nak(nak), .o_resume_en(res_en),
    .o_susp_exit(sexit), .o_disc_seen(seen), .o_wake_early_err(eerr),
    .o_wake_overrun_err(oerr));

  function automatic int exp_lim(logic [1:0] s, logic [1:0] d, logic [7:0] m);
    int b;
    if (s == 2'b00) b = (d == 2'b10) ? 1003 : (d == 2'b01) ? 3003 : 125;
    else            b = (d == 2'b10) ? 1003 : 3;
    return b + int'(m);
  endfunction

  function automatic logic [NUM_EP-1:0] exp_nak(logic g, logic [NUM_EP-1:0] f);
    return ~f | ({NUM_EP{g}} & NPM);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic disc_case(logic [1:0] s, logic [1:0] d, logic [7:0] m, logic flip);
    int l;
    l = exp_lim(s, d, m);
    spd = s; st = d; margin = m; sd = 1;
    step(1);
    if (flip) begin st = 2'b01; margin = 8'd255; end
    step(l - 1);
    check("R5 seen before limit", seen, 0);
    step(1);
    check(flip ? "R6 latched limit" : "R5 seen at limit", seen, 1);
    check("R1 opmode nodrive", opm, 2'b01);
    sd = 0; st = d; margin = 0;
    #1;
    check("R6 seen clears", seen, 0);
    check("R2 opmode normal", opm, 2'b00);
    step(1);
  endtask

  task automatic wake_hold(int h);
    rw = 1;
    step(1);
    step(h);
    rw = 0;
    step(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    step(3);
    // R12 reset state
    check("R12 opmode", opm, 2'b00);
    check("R12 nak follows fifo", nak, 4'b0101);
    check("R12 flags", {res_en, sexit, seen, eerr, oerr}, 5'b0);
    rst_n = 1;
    step(1);

    // R3 R4 R1 R2 random combinational vectors
    for (int i = 0; i < 200; i++) begin
      logic [31:0] r;
      r = $urandom;
      fifo = r[3:0]; gn = r[4]; sd = r[5]; tick = r[6];
      #2;
      check(gn ? "R3 global nak" : "R4 fifo handshake", nak, exp_nak(gn, fifo));
      check(sd ? "R1 opmode" : "R2 opmode", opm, sd ? 2'b01 : 2'b00);
      step(1);
    end
    sd = 0; gn = 0; tick = 1;
    step(2);

    // R5 all speed/state combinations, random margins
    for (int s = 0; s < 3; s++)
      for (int d = 0; d < 3; d++)
        disc_case(2'(s), 2'(d), 8'($urandom_range(0, 255)), 1'b0);
    disc_case(2'b00, 2'b00, 8'd10, 1'b1);   // R6 state/margin change after rise
    disc_case(2'b01, 2'b01, 8'd0, 1'b0);    // R5 shortest limit

    // R7 accepted request while suspended
    st = 2'b10; rw = 1;
    step(1);
    check("R7 resume on", res_en, 1);
    check("R7 exit pulse", sexit, 1);
    step(1);
    check("R7 exit single", sexit, 0);
    st = 2'b00; #1;
    check("R10 resume gated by state", res_en, 0);
    st = 2'b10;
    step(1998);
    rw = 0;
    step(1);
    check("R7 resume off after clear", res_en, 0);
    check("R8 no error normal", {eerr, oerr}, 2'b00);

    // R8 boundaries
    wake_hold(999);
    check("R8 early at 999", eerr, 1);
    step(5);
    check("R11 early sticky", eerr, 1);
    wake_hold(1000);
    check("R8 no early at 1000", eerr, 0);

    // R9 overrun
    rw = 1;
    step(1);
    step(14999);
    check("R9 still resuming", {res_en, oerr}, 2'b10);
    step(1);
    check("R9 overrun stop", {res_en, oerr}, 2'b01);
    rw = 0;
    step(1);
    check("R9 no early after overrun", {eerr, oerr}, 2'b01);

    // R10 ignored while soft disconnect
    sd = 1; rw = 1;
    step(1);
    check("R10 ignored no pulse", {res_en, sexit}, 2'b00);
    sd = 0;
    step(3);
    check("R10 not armed later", res_en, 0);
    rw = 0;
    step(1);
    check("R11 flags unchanged", {eerr, oerr}, 2'b01);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule